// File: doc/BRIEF.md
# Boot Overlay Mapping and Lock Permission Controller

This block decides whether a small boot memory replaces the top of an 8-bit controller's 64 KB code space, and which address the core fetches after reset. Two reset-time conditions can open the boot window and move the reset vector to F000h. The first is a boot-request pin held low. The second is a programmed non-volatile jump bit. The boot-request pin is resynchronised before use. Once reset has been released, the captured vector holds until the next reset.

Software can also open or close the window at run time. It does so by writing an enable flag in a small auxiliary control register. The current value of the flag is always readable.

Three non-volatile lock bits are decoded into a protection level from 0 to 3. Each higher level removes one more permission. Permissions are removed in this order: hardware programming, then hardware verify, then external execution. Internal execution and software programming remain allowed at every level.

Top module: `boot_map_ctrl`

## Requirements
- R1: If the pin is high and the jump bit is 0 during reset, then after release `reset_vector` is 0000h and the boot enable flag is 0.
- R2: If `boot_req_n` is held low for the whole reset, which lasts at least 3 clock cycles, then after release `reset_vector` is F000h and the boot enable flag is 1.
- R3: If `jump_prog` is 1 (programmed) during reset, then after release `reset_vector` is F000h and the boot enable flag is 1, whatever the state of the pin.
- R4: After release, `reset_vector` does not change until the next reset, even if the pin or the jump bit changes.
- R5: `fetch_from_boot` is 1 exactly when the boot enable flag is 1 and `fetch_addr` lies between F000h and FFFFh. In every other case it is 0.
- R6: A write with `reg_wr`=1 and `reg_addr`=A2h loads bit 5 of `reg_wdata` into the boot enable flag at the next clock edge. A write to any other address leaves the flag unchanged.
- R7: When `reg_addr` is A2h, `reg_rdata` shows the flag in bit 5 and 0 in every other bit. Any other address reads as 00h.
- R8: When `lock_prog` is 000 (bit = 1 means programmed), all five permission outputs are 1.
- R9: When `lock_prog` is 001 (level 1), only `perm_hw_prog` is 0.
- R10: When `lock_prog[1]`=1 and `lock_prog[2]`=0 (level 2, bit 0 is don't care), both `perm_hw_prog` and `perm_hw_verify` are 0, and external execution stays 1.
- R11: When `lock_prog[2]`=1 (level 3), `perm_ext_exec` is also 0. `perm_int_exec` and `perm_sw_prog` are 1 for every lock code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_req_n | input | 1 | Boot request pin, active low, asynchronous |
| jump_prog | input | 1 | Non-volatile jump bit, 1 = programmed |
| lock_prog | input | 3 | Non-volatile lock bits, 1 = programmed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| fetch_addr | input | 16 | Code fetch address |
| fetch_from_boot | output | 1 | 1 = serve fetch from boot memory |
| reset_vector | output | 16 | First fetch address after reset |
| perm_int_exec | output | 1 | Internal execution allowed |
| perm_ext_exec | output | 1 | External execution allowed |
| perm_hw_verify | output | 1 | Hardware verify allowed |
| perm_hw_prog | output | 1 | Hardware programming allowed |
| perm_sw_prog | output | 1 | Software programming allowed |

## Verification
The assertions assume that `jump_prog` is steady over the last two reset cycles. They also assume that `boot_req_n` does not change during reset, so that the synchronizer output has settled before release. The directed tasks respect both assumptions. They set the pin and the jump bit before raising `rst`, and they hold reset for five cycles. Changes to the pin and the jump bit are made only after release, and only in order to check that the vector holds.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;
   localparam int CODE_AW   = 16;
   localparam int BOOT_AW   = 12;
   localparam int LOCK_W    = 3;
   localparam int REG_AW    = 8;
   localparam int REG_DW    = 8;

   typedef struct packed {
      logic int_exec;
      logic ext_exec;
      logic hw_verify;
      logic hw_prog;
      logic sw_prog;
   } perm_t;
endpackage

// File: rtl/boot_req_sync.sv
module boot_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   initial assert (STAGES >= 2) else $error("boot_req_sync: STAGES must be at least 2");

   always_ff @(posedge clk) begin
      chain[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         chain[i] <= chain[i-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/lock_level_dec.sv
module lock_level_dec
   import boot_map_pkg::*;
#(
   parameter int LW = LOCK_W
) (
   input  logic [LW-1:0] lock_prog,
   output perm_t         perm
);
   // level_gt[j] is 1 when the protection level is above j,
   // which means some lock bit at index j or higher is programmed
   logic [LW-1:0] level_gt;

   initial assert (LW == 3) else $error("lock_level_dec: exactly three lock bits are decoded");

   for (genvar j = 0; j < LW; j++) begin : g_lvl
      assign level_gt[j] = |lock_prog[LW-1:j];
   end

   always_comb begin
      perm.int_exec  = 1'b1;
      perm.sw_prog   = 1'b1;
      perm.hw_prog   = ~level_gt[0];
      perm.hw_verify = ~level_gt[1];
      perm.ext_exec  = ~level_gt[2];
   end
endmodule

// File: rtl/boot_overlay.sv
module boot_overlay #(
   parameter int              AW       = 16,
   parameter int              WIN_AW   = 12,
   parameter int              RAW      = 8,
   parameter int              RDW      = 8,
   parameter logic [RAW-1:0]  AUX_ADDR = 8'hA2,
   parameter int              EN_BIT   = 5
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           boot_req_sync_n,
   input  logic           jump_prog,
   input  logic           reg_wr,
   input  logic [RAW-1:0] reg_addr,
   input  logic [RDW-1:0] reg_wdata,
   output logic [RDW-1:0] reg_rdata,
   input  logic [AW-1:0]  fetch_addr,
   output logic           fetch_from_boot,
   output logic [AW-1:0]  reset_vector,
   output logic           boot_en
);
   localparam int            TAG_W   = AW - WIN_AW;
   localparam logic [AW-1:0] BOOT_VEC = {{TAG_W{1'b1}}, {WIN_AW{1'b0}}};

   initial assert (WIN_AW < AW) else $error("boot_overlay: window must be smaller than code space");
   initial assert (EN_BIT < RDW) else $error("boot_overlay: enable bit outside register");

   logic boot_cond;
   logic aux_hit;

   assign boot_cond = ~boot_req_sync_n | jump_prog;
   assign aux_hit   = (reg_addr == AUX_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         boot_en      <= boot_cond;
         reset_vector <= boot_cond ? BOOT_VEC : '0;
      end else if (reg_wr && aux_hit) begin
         boot_en      <= reg_wdata[EN_BIT];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (aux_hit) reg_rdata[EN_BIT] = boot_en;
   end

   assign fetch_from_boot = boot_en && (&fetch_addr[AW-1:WIN_AW]);
endmodule

// File: rtl/boot_map_ctrl.sv
module boot_map_ctrl
   import boot_map_pkg::*;
#(
   parameter logic [REG_AW-1:0] AUX_ADDR    = 8'hA2,
   parameter int                EN_BIT      = 5,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              boot_req_n,
   input  logic              jump_prog,
   input  logic [LOCK_W-1:0] lock_prog,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic [CODE_AW-1:0] fetch_addr,
   output logic              fetch_from_boot,
   output logic [CODE_AW-1:0] reset_vector,
   output logic              perm_int_exec,
   output logic              perm_ext_exec,
   output logic              perm_hw_verify,
   output logic              perm_hw_prog,
   output logic              perm_sw_prog
);
   logic  req_n_s;
   logic  boot_en;
   perm_t perm;

   boot_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .din  (boot_req_n),
      .dout (req_n_s)
   );

   boot_overlay #(
      .AW       (CODE_AW),
      .WIN_AW   (BOOT_AW),
      .RAW      (REG_AW),
      .RDW      (REG_DW),
      .AUX_ADDR (AUX_ADDR),
      .EN_BIT   (EN_BIT)
   ) u_ovl (
      .clk             (clk),
      .rst             (rst),
      .boot_req_sync_n (req_n_s),
      .jump_prog       (jump_prog),
      .reg_wr          (reg_wr),
      .reg_addr        (reg_addr),
      .reg_wdata       (reg_wdata),
      .reg_rdata       (reg_rdata),
      .fetch_addr      (fetch_addr),
      .fetch_from_boot (fetch_from_boot),
      .reset_vector    (reset_vector),
      .boot_en         (boot_en)
   );

   lock_level_dec #(.LW(LOCK_W)) u_lock (
      .lock_prog (lock_prog),
      .perm      (perm)
   );

   assign perm_int_exec  = perm.int_exec;
   assign perm_ext_exec  = perm.ext_exec;
   assign perm_hw_verify = perm.hw_verify;
   assign perm_hw_prog   = perm.hw_prog;
   assign perm_sw_prog   = perm.sw_prog;
endmodule

// File: rtl/boot_map_chk.sv
module boot_map_chk (
   input logic        clk,
   input logic        rst,
   input logic        jump_prog,
   input logic [2:0]  lock_prog,
   input logic [15:0] fetch_addr,
   input logic        fetch_from_boot,
   input logic [15:0] reset_vector,
   input logic        perm_ext_exec,
   input logic        perm_hw_verify,
   input logic        perm_hw_prog
);
   assert_vec_legal_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (reset_vector == 16'h0000 || reset_vector == 16'hF000));

   assert_jump_vector_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && $past(jump_prog)) |-> (reset_vector == 16'hF000));

   assert_vec_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $stable(reset_vector));

   assert_window_R5: assert property (@(posedge clk) disable iff (rst)
      fetch_from_boot |-> (fetch_addr[15:12] == 4'hF));

   assert_level1_R9: assert property (@(posedge clk) disable iff (rst)
      (lock_prog != 3'b000) |-> !perm_hw_prog);

   assert_cumulative_R10: assert property (@(posedge clk) disable iff (rst)
      perm_hw_verify |-> perm_ext_exec);

   assert_level3_R11: assert property (@(posedge clk) disable iff (rst)
      lock_prog[2] |-> (!perm_ext_exec && !perm_hw_verify));
endmodule

bind boot_map_ctrl boot_map_chk u_chk (
   .clk             (clk),
   .rst             (rst),
   .jump_prog       (jump_prog),
   .lock_prog       (lock_prog),
   .fetch_addr      (fetch_addr),
   .fetch_from_boot (fetch_from_boot),
   .reset_vector    (reset_vector),
   .perm_ext_exec   (perm_ext_exec),
   .perm_hw_verify  (perm_hw_verify),
   .perm_hw_prog    (perm_hw_prog)
);

// File: tb/tb_boot_map_ctrl.sv
module tb_boot_map_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        boot_req_n = 1'b1;
   logic        jump_prog = 1'b0;
   logic [2:0]  lock_prog = 3'b000;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'hA2;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [15:0] fetch_addr = 16'h0000;
   logic        fetch_from_boot;
   logic [15:0] reset_vector;
   logic        perm_int_exec, perm_ext_exec, perm_hw_verify, perm_hw_prog, perm_sw_prog;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   boot_map_ctrl dut (
      .clk(clk), .rst(rst), .boot_req_n(boot_req_n), .jump_prog(jump_prog),
      .lock_prog(lock_prog), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
      .fetch_from_boot(fetch_from_boot), .reset_vector(reset_vector),
      .perm_int_exec(perm_int_exec), .perm_ext_exec(perm_ext_exec),
      .perm_hw_verify(perm_hw_verify), .perm_hw_prog(perm_hw_prog),
      .perm_sw_prog(perm_sw_prog)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic apply_reset(input logic pin_n, input logic jmp);
      @(negedge clk);
      boot_req_n = pin_n;
      jump_prog  = jmp;
      rst        = 1'b1;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_addr  = 8'hA2;
   endtask

   task automatic t_plain_reset;
      apply_reset(1'b1, 1'b0);
      check("R1 vector", reset_vector, 16'h0000);
      reg_addr = 8'hA2; #1;
      check("R1 enable flag", {8'h00, reg_rdata}, 16'h0000);
      fetch_addr = 16'hF000; #1;
      check("R5 disabled window", {15'b0, fetch_from_boot}, 16'h0000);
   endtask

   task automatic t_pin_reset;
      apply_reset(1'b0, 1'b0);
      boot_req_n = 1'b1;
      check("R2 vector", reset_vector, 16'hF000);
      reg_addr = 8'hA2; #1;
      check("R2 enable flag", {8'h00, reg_rdata}, 16'h0020);
      fetch_addr = 16'hFFFF; #1;
      check("R5 top of window", {15'b0, fetch_from_boot}, 16'h0001);
      fetch_addr = 16'hEFFF; #1;
      check("R5 below window", {15'b0, fetch_from_boot}, 16'h0000);
   endtask

   task automatic t_jump_reset;
      apply_reset(1'b1, 1'b1);
      check("R3 vector", reset_vector, 16'hF000);
      reg_addr = 8'hA2; #1;
      check("R3 enable flag", {8'h00, reg_rdata}, 16'h0020);
      fetch_addr = 16'hF000; #1;
      check("R5 base of window", {15'b0, fetch_from_boot}, 16'h0001);
   endtask

   task automatic t_vector_hold;
      apply_reset(1'b1, 1'b0);
      boot_req_n = 1'b0;
      jump_prog  = 1'b1;
      repeat (6) @(negedge clk);
      check("R4 vector holds", reset_vector, 16'h0000);
      boot_req_n = 1'b1;
      jump_prog  = 1'b0;
   endtask

   task automatic t_soft_enable;
      apply_reset(1'b1, 1'b0);
      reg_write(8'hA3, 8'h20);
      #1;
      check("R6 other address ignored", {8'h00, reg_rdata}, 16'h0000);
      reg_write(8'hA2, 8'h20);
      #1;
      check("R6 set flag", {8'h00, reg_rdata}, 16'h0020);
      fetch_addr = 16'hF123; #1;
      check("R5 soft window", {15'b0, fetch_from_boot}, 16'h0001);
      reg_addr = 8'h10; #1;
      check("R7 other address reads 0", {8'h00, reg_rdata}, 16'h0000);
      reg_addr = 8'hA2;
      reg_write(8'hA2, 8'hDF);
      #1;
      check("R6 clear flag", {8'h00, reg_rdata}, 16'h0000);
      check("R7 only bit 5 read", {8'h00, reg_rdata}, 16'h0000);
      check("R4 vector after writes", reset_vector, 16'h0000);
   endtask

   task automatic t_lock_levels;
      for (int c = 0; c < 8; c++) begin
         logic [4:0] exp;
         lock_prog = c[2:0];
         #1;
         // order: int_exec, ext_exec, hw_verify, hw_prog, sw_prog
         if (c[2])      exp = 5'b10001;   // R11 level 3
         else if (c[1]) exp = 5'b11001;   // R10 level 2
         else if (c[0]) exp = 5'b11101;   // R9 level 1
         else           exp = 5'b11111;   // R8 level 0
         check(c[2] ? "R11 lock" : c[1] ? "R10 lock" : c[0] ? "R9 lock" : "R8 lock",
               {11'b0, perm_int_exec, perm_ext_exec, perm_hw_verify, perm_hw_prog, perm_sw_prog},
               {11'b0, exp});
         @(negedge clk);
      end
      lock_prog = 3'b000;
   endtask

   initial begin
      #200000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_plain_reset();
      t_pin_reset();
      t_jump_reset();
      t_vector_hold();
      t_soft_enable();
      t_lock_levels();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule